// File: doc/BRIEF.md
# Set-Associative Tag Directory with Tree Pseudo-LRU Victim Selection

This block holds the tags, the valid bits and the replacement state for a small set-associative cache. A requester presents a set index and a tag with a lookup strobe. One clock later the block reports whether a valid way holds that tag and, if so, which way. On a miss it also names the way the requester should replace. The requester then issues a fill command that carries the index, the new tag and the way to write, which is normally the victim it was just given.

Replacement state is a binary tree of toggle bits per set, one bit fewer than the number of ways. For four ways that is three bits per set, in place of the state needed to record a full ordering of the ways. The root bit chooses a pair of ways and one bit per pair chooses a way within it. A hit or a fill sets the bits on that way's path so that they point away from it. Ways that are invalid are always used before the tree is consulted. A flush input empties the whole directory in one clock. The number of ways must be a power of two and at least two. A set count that is a power of two is assumed.

Top module: `tag_plru_array`

## Requirements
- R1: While reset is held, and in the first clock after it is released, `rsp_valid` and `rsp_hit` are low. After reset every way of every set is invalid and every tree bit is zero, so the first miss to any set names way 0.
- R2: `rsp_valid` is high in exactly the clock that follows a clock in which `acc_valid` was high and `flush` low, and is low otherwise. `rsp_hit` is low whenever `rsp_valid` is low.
- R3: A lookup whose tag equals the stored tag of a valid way in the indexed set returns `rsp_hit` = 1 and `rsp_way` = that way's number. A tag held only in an invalid way does not hit.
- R4: On a miss to a set that has at least one invalid way, `rsp_victim` is the lowest-numbered invalid way, whatever the tree bits hold.
- R5: On a miss to a set whose ways are all valid, `rsp_victim` follows the tree. For four ways, bit 0 is the root (0 selects ways 0 and 1, 1 selects ways 2 and 3), bit 1 picks inside the lower pair (0 gives way 0, 1 gives way 1) and bit 2 picks inside the upper pair (0 gives way 2, 1 gives way 3). On a miss `rsp_way` is 0.
- R6: A hit to way w sets each tree bit on w's path to the value that points away from w. The other bits of that set and the state of every other set are not changed. A miss lookup changes no state.
- R7: A fill writes the tag into way `fill_way` of set `fill_index`, marks that way valid and updates that set's tree bits as a hit to that way would. A lookup in the same clock sees the directory as it was before the fill.
- R8: `flush` clears every valid bit and every tree bit. A lookup or a fill presented in the same clock is ignored, and no response follows it.
- R9: When a lookup hits in set s and a fill targets set s in the same clock, the tree of set s ends as if the hit's update had been applied first and the fill's update second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all ways and clear all tree bits |
| acc_valid | input | 1 | Lookup strobe |
| acc_index | input | IDX_W | Set index of the lookup |
| acc_tag | input | TAG_W | Tag of the lookup |
| fill_valid | input | 1 | Fill strobe |
| fill_index | input | IDX_W | Set index of the fill |
| fill_tag | input | TAG_W | Tag to store |
| fill_way | input | WAY_W | Way to overwrite |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a valid matching way |
| rsp_way | output | WAY_W | Way that hit, 0 on a miss |
| rsp_victim | output | WAY_W | Way to replace; meaningful on a miss |

## Verification
The hardest states to reach from the ports are full sets whose tree bits are in each of their eight combinations, and a lookup hit that lands in the same clock as a fill to the same set. The bench first fills every set through miss-then-fill pairs. It then sweeps every ordered pair of hit ways on one full set and probes the victim with a tag that cannot hit, so that every tree state is reached through the ports. A partly filled set after a flush, where the tree and the lowest invalid way disagree, shows that invalid ways are used first. A lookup and a fill are also driven together on one set and the result is compared with a model that applies the two updates in order.

// File: rtl/plru_pick.sv
// plru_pick: walks a pseudo-LRU toggle tree from the root to a leaf and
// returns the way the tree points at.
// Assumes: NUM_WAYS is a power of two, >= 2. Tree bits are heap-ordered:
// node n (root = 1) is bit n-1, and its children are nodes 2n and 2n+1.
// A bit value of 0 selects the lower child, 1 the upper child.
module plru_pick #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-2:0] tree,
    output logic [WAY_W-1:0]    victim
);

    // Descend one level per tree depth, following the stored bit.
    always_comb begin
        int node;
        node = 1;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            node = 2 * node + int'(tree[node-1]);
        end
        victim = WAY_W'(node - NUM_WAYS);
    end

endmodule

// File: rtl/plru_touch.sv
// plru_touch: returns the tree bits after a use of one way, with every bit
// on that way's path pointing away from it; bits off the path are kept.
// Assumes: same heap ordering and bit sense as plru_pick.
module plru_touch #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-2:0] tree,
    input  logic [WAY_W-1:0]    way,
    output logic [NUM_WAYS-2:0] tree_next
);

    // Climb from the leaf to the root, steering each parent to the sibling.
    always_comb begin
        int node;
        int parent;
        tree_next = tree;
        node = int'(way) + NUM_WAYS;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            parent = node / 2;
            tree_next[parent-1] = (node % 2 == 0);
            node = parent;
        end
    end

endmodule

// File: rtl/tag_match.sv
// tag_match: compares a probe tag against every way of one set.
// Reports a hit with the lowest matching valid way, and the lowest
// invalid way for allocation.
// Assumes: tag_row packs way w at bits [w*TAG_W +: TAG_W].
module tag_match #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]       valid_vec,
    input  logic [NUM_WAYS*TAG_W-1:0] tag_row,
    input  logic [TAG_W-1:0]          probe_tag,
    output logic                      hit,
    output logic [WAY_W-1:0]          hit_way,
    output logic                      any_free,
    output logic [WAY_W-1:0]          free_way
);

    logic [NUM_WAYS-1:0] match;

    // One comparator per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = valid_vec[w] && (tag_row[w*TAG_W +: TAG_W] == probe_tag);
    end

    // Priority pick of the lowest matching and the lowest invalid way.
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w])      hit_way  = WAY_W'(w);
            if (!valid_vec[w]) free_way = WAY_W'(w);
        end
    end

    assign hit      = |match;
    assign any_free = ~&valid_vec;

endmodule

// File: rtl/tag_plru_array.sv
// tag_plru_array: tag directory for a set-associative cache with a tree
// pseudo-LRU replacement state per set.
// A lookup is answered one clock after its strobe; a hit updates the tree.
// A fill writes tag and valid for a given way and updates the tree.
// Flush empties the directory and overrides lookup and fill.
// Assumes: NUM_WAYS a power of two >= 2, NUM_SETS a power of two,
// IDX_W = log2(NUM_SETS). Tags are not reset; valid bits guard them.
module tag_plru_array #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 20,
    parameter int IDX_W    = $clog2(NUM_SETS),
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_index,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_index,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [WAY_W-1:0] fill_way,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic [WAY_W-1:0] rsp_victim
);

    localparam int TREE_W = NUM_WAYS - 1;

    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    logic [TREE_W-1:0]   tree_q  [NUM_SETS];
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];

    logic [NUM_WAYS*TAG_W-1:0] acc_row;
    logic [NUM_WAYS-1:0]       acc_vvec;
    logic                      lk_hit;
    logic [WAY_W-1:0]          lk_way;
    logic                      lk_free;
    logic [WAY_W-1:0]          lk_free_way;
    logic [WAY_W-1:0]          tree_victim;
    logic [WAY_W-1:0]          victim_sel;
    logic [TREE_W-1:0]         tree_after_hit;
    logic [TREE_W-1:0]         tree_fill_base;
    logic [TREE_W-1:0]         tree_after_fill;
    logic                      lk_go;
    logic                      fill_go;
    logic                      same_set;
    logic                      valid_any;

    assign lk_go    = acc_valid && !flush;
    assign fill_go  = fill_valid && !flush;
    assign same_set = (fill_index == acc_index);

    // Gather the tags of the looked-up set into one packed row.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            acc_row[w*TAG_W +: TAG_W] = tag_q[acc_index][w];
        end
    end

    assign acc_vvec = valid_q[acc_index];

    tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .valid_vec (acc_vvec),
        .tag_row   (acc_row),
        .probe_tag (acc_tag),
        .hit       (lk_hit),
        .hit_way   (lk_way),
        .any_free  (lk_free),
        .free_way  (lk_free_way)
    );

    plru_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
        .tree   (tree_q[acc_index]),
        .victim (tree_victim)
    );

    // Invalid ways take priority over the tree choice.
    assign victim_sel = lk_free ? lk_free_way : tree_victim;

    plru_touch #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_touch_hit (
        .tree      (tree_q[acc_index]),
        .way       (lk_way),
        .tree_next (tree_after_hit)
    );

    // A fill to the set just hit builds on the hit's update.
    assign tree_fill_base = (lk_go && lk_hit && same_set) ? tree_after_hit
                                                          : tree_q[fill_index];

    plru_touch #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_touch_fill (
        .tree      (tree_fill_base),
        .way       (fill_way),
        .tree_next (tree_after_fill)
    );

    // Tag storage: written on fill only, no reset needed.
    always_ff @(posedge clk) begin
        if (rst_n && fill_go) begin
            tag_q[fill_index][fill_way] <= fill_tag;
        end
    end

    // Valid bits and tree state: reset, flush, hit and fill updates.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                valid_q[s] <= '0;
                tree_q[s]  <= '0;
            end
        end else begin
            if (lk_go && lk_hit && !(fill_go && same_set)) begin
                tree_q[acc_index] <= tree_after_hit;
            end
            if (fill_go) begin
                valid_q[fill_index][fill_way] <= 1'b1;
                tree_q[fill_index]            <= tree_after_fill;
            end
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_way    <= '0;
            rsp_victim <= '0;
        end else begin
            rsp_valid <= lk_go;
            rsp_hit   <= lk_go && lk_hit;
            if (lk_go) begin
                rsp_way    <= lk_hit ? lk_way : '0;
                rsp_victim <= victim_sel;
            end
        end
    end

    // Any valid bit anywhere, for the flush check.
    always_comb begin
        valid_any = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) begin
            valid_any = valid_any | (|valid_q[s]);
        end
    end

    // R2: an accepted lookup is answered in the next clock.
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !flush) |=> rsp_valid);

    // R2: no response without an accepted lookup.
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !flush) |=> !rsp_valid);

    // R3: a hit is only reported with a response.
    p_hit_needs_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R4: a miss with a free way never picks a valid way.
    p_victim_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !lk_hit && lk_free) |-> !acc_vvec[victim_sel]);

    // R7: a fill leaves its way valid.
    p_fill_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> valid_q[$past(fill_index)][$past(fill_way)]);

    // R8: flush leaves nothing valid.
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid_any);

endmodule

// File: tb/test_tag_plru_array.sv
module test_tag_plru_array;

    localparam int SETS = 16;
    localparam int WAYS = 4;
    localparam int TW   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          acc_valid = 1'b0;
    logic [3:0]    acc_index = '0;
    logic [TW-1:0] acc_tag = '0;
    logic          fill_valid = 1'b0;
    logic [3:0]    fill_index = '0;
    logic [TW-1:0] fill_tag = '0;
    logic [1:0]    fill_way = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [1:0]    rsp_way;
    logic [1:0]    rsp_victim;

    int checks = 0;
    int errors = 0;
    int probe_n = 0;

    // Reference state kept by the bench.
    logic          m_valid [SETS][WAYS];
    logic [TW-1:0] m_tag   [SETS][WAYS];
    logic [2:0]    m_tree  [SETS];

    always #4 clk = ~clk;

    tag_plru_array i_tag_plru_array (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .acc_valid(acc_valid), .acc_index(acc_index), .acc_tag(acc_tag),
        .fill_valid(fill_valid), .fill_index(fill_index), .fill_tag(fill_tag),
        .fill_way(fill_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim(rsp_victim)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int s = 0; s < SETS; s++) begin
            m_tree[s] = 3'b000;
            for (int w = 0; w < WAYS; w++) m_valid[s][w] = 1'b0;
        end
    endtask

    function automatic int m_victim(input int s);
        logic [2:0] b;
        for (int w = 0; w < WAYS; w++) if (!m_valid[s][w]) return w;
        b = m_tree[s];
        if (b[0]) return b[2] ? 3 : 2;
        return b[1] ? 1 : 0;
    endfunction

    task automatic m_touch(input int s, input int w);
        if (w < 2) begin
            m_tree[s][0] = 1'b1;
            m_tree[s][1] = (w == 0);
        end else begin
            m_tree[s][0] = 1'b0;
            m_tree[s][2] = (w == 2);
        end
    endtask

    function automatic int m_hitway(input int s, input logic [TW-1:0] t);
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic logic [TW-1:0] base_tag(input int s, input int k);
        return TW'(s * 16 + k + 1);
    endfunction

    function automatic logic [TW-1:0] next_probe();
        probe_n++;
        return TW'(32'hF0000 + probe_n);
    endfunction

    // Lookup, compare the response with the model, then update the model.
    task automatic lookup(input int s, input logic [TW-1:0] t, input string req);
        int hw;
        int vic;
        hw  = m_hitway(s, t);
        vic = m_victim(s);
        @(negedge clk);
        acc_valid = 1'b1; acc_index = 4'(s); acc_tag = t;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " rsp_valid"}, int'(rsp_valid), 1);
        check({req, " rsp_hit"}, int'(rsp_hit), (hw >= 0) ? 1 : 0);
        check({req, " rsp_way"}, int'(rsp_way), (hw >= 0) ? hw : 0);
        if (hw < 0) check({req, " rsp_victim"}, int'(rsp_victim), vic);
        else        m_touch(s, hw);
    endtask

    task automatic fill(input int s, input logic [TW-1:0] t, input int w);
        @(negedge clk);
        fill_valid = 1'b1; fill_index = 4'(s); fill_tag = t; fill_way = 2'(w);
        @(negedge clk);
        fill_valid = 1'b0;
        m_valid[s][w] = 1'b1; m_tag[s][w] = t; m_touch(s, w);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_clear();
        repeat (4) @(negedge clk);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        check("R1 rsp_hit in reset", int'(rsp_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        check("R2 idle has no hit", int'(rsp_hit), 0);

        // R1/R4/R7: fill every set through miss-then-fill, ways in order.
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < WAYS; k++) begin
                lookup(s, base_tag(s, k), "R4 miss on filling set");
                check("R4 victim is next free way", m_victim(s), k);
                fill(s, base_tag(s, k), m_victim(s));
            end
        end

        // R3/R6: every stored tag now hits in its own way.
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < WAYS; k++) begin
                lookup(s, base_tag(s, k), "R3 hit on stored tag");
            end
        end

        // R5/R6: all ordered pairs of hits on a full set, then a victim probe.
        for (int a = 0; a < WAYS; a++) begin
            for (int b = 0; b < WAYS; b++) begin
                lookup(5, m_tag[5][a], "R6 first hit");
                lookup(5, m_tag[5][b], "R6 second hit");
                lookup(5, next_probe(), "R5 tree victim");
                lookup(6, next_probe(), "R6 neighbour set untouched");
            end
        end

        // R7: replacing a way evicts the old tag.
        begin
            int v;
            logic [TW-1:0] old_t;
            lookup(7, 20'h80001, "R7 miss before fill");
            v = m_victim(7);
            old_t = m_tag[7][v];
            fill(7, 20'h80001, v);
            lookup(7, 20'h80001, "R7 new tag hits");
            lookup(7, old_t, "R7 evicted tag misses");
        end

        // R9: hit and fill to the same set in one clock.
        begin
            int hw;
            hw = 1;
            @(negedge clk);
            acc_valid = 1'b1; acc_index = 4'd9; acc_tag = m_tag[9][hw];
            fill_valid = 1'b1; fill_index = 4'd9; fill_tag = 20'h80002; fill_way = 2'd2;
            @(negedge clk);
            acc_valid = 1'b0; fill_valid = 1'b0;
            check("R9 rsp_hit with fill", int'(rsp_hit), 1);
            check("R9 rsp_way with fill", int'(rsp_way), hw);
            m_touch(9, hw);
            m_valid[9][2] = 1'b1; m_tag[9][2] = 20'h80002; m_touch(9, 2);
            lookup(9, next_probe(), "R9 victim after hit then fill");
            lookup(9, 20'h80002, "R9 filled tag hits");
            lookup(9, m_tag[9][0], "R9 hit way0");
            lookup(9, next_probe(), "R9 victim after way0 hit");
        end

        // R7: a lookup in the fill's clock sees the old contents.
        begin
            int v;
            v = m_victim(11);
            @(negedge clk);
            acc_valid = 1'b1; acc_index = 4'd11; acc_tag = 20'h80003;
            fill_valid = 1'b1; fill_index = 4'd11; fill_tag = 20'h80003; fill_way = 2'(v);
            @(negedge clk);
            acc_valid = 1'b0; fill_valid = 1'b0;
            check("R7 same-clock lookup misses", int'(rsp_hit), 0);
            m_valid[11][v] = 1'b1; m_tag[11][v] = 20'h80003; m_touch(11, v);
            lookup(11, 20'h80003, "R7 tag visible next clock");
        end

        // R8: flush with a lookup and a fill in the same clock.
        @(negedge clk);
        flush = 1'b1;
        acc_valid = 1'b1; acc_index = 4'd2; acc_tag = base_tag(2, 0);
        fill_valid = 1'b1; fill_index = 4'd4; fill_tag = 20'h80004; fill_way = 2'd3;
        @(negedge clk);
        flush = 1'b0; acc_valid = 1'b0; fill_valid = 1'b0;
        check("R8 no response to flushed lookup", int'(rsp_valid), 0);
        check("R8 no hit after flush clock", int'(rsp_hit), 0);
        m_clear();
        lookup(2, base_tag(2, 0), "R8 old tag misses after flush");
        check("R8 victim way0 after flush", m_victim(2), 0);
        lookup(4, 20'h80004, "R8 flushed fill ignored");

        // R4: free ways beat the tree on a partly filled set.
        fill(3, 20'h80010, 0);
        lookup(3, next_probe(), "R4 free way 1 over tree way 2");
        check("R4 model picks way1", m_victim(3), 1);
        fill(3, 20'h80011, 3);
        lookup(3, next_probe(), "R4 free way 1 again");
        fill(3, 20'h80012, 1);
        lookup(3, next_probe(), "R4 last free way 2");
        fill(3, 20'h80013, 2);
        lookup(3, next_probe(), "R5 tree victim on refilled set");
        for (int s = 0; s < SETS; s++) begin
            lookup(s, next_probe(), "R4 sweep after partial fill");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule